// File: doc/BRIEF.md
# Host-to-Slave Byte Mailbox Channel

This block is a one-byte mailbox in each direction between an external host and an embedded slave processor. The host reaches it through a decoded 16-bit I/O port with separate read and write strobes. The slave reaches it through a small register bus with a two-bit register select. A host write fills the inbound byte. The address bit that selects the port also records whether the byte is a command or plain data. A host read returns either the outbound byte or a status byte. The status byte reports both buffer-full flags and the command/data marker.

A host access belongs to this channel only when its address matches a base address supplied on an input. Address bit 2 is left out of the comparison, so the channel occupies two host ports. All state changes on one rising clock edge. Host read data is registered and is returned with a valid strobe one cycle after the read strobe. Slave read data is combinational from the current register contents.

Top module: `hmbox_channel`

## Requirements
- R1: A host access hits the channel only when `host_addr[15:3]` equals `cfg_base[15:3]` and `host_addr[1:0]` equals `cfg_base[1:0]`. The value of `host_addr[2]` plays no part in the match.
- R2: A hitting host write with `host_addr[2]`=0 loads `host_wdata` into the inbound byte and clears the command marker to 0 (data).
- R3: A hitting host write with `host_addr[2]`=1 loads `host_wdata` into the inbound byte and sets the command marker to 1 (command).
- R4: A hitting host read with `host_addr[2]`=0 raises `host_rvalid` in the next cycle, with `host_rdata` equal to the outbound byte as it stood at the read edge.
- R5: A hitting host read with `host_addr[2]`=1 returns the status byte in the next cycle, as it stood at the read edge. Its layout is bit 0 = outbound full, bit 1 = inbound full, bit 3 = command marker, and every other bit is 0.
- R6: A host access that does not hit leaves `host_rvalid` low and `host_rdata` at 0x00 in the next cycle. It changes no register or flag.
- R7: The inbound-full flag is set by a hitting host write. It is cleared by a slave read with `slv_sel`=0. When both happen in the same cycle, the flag stays set.
- R8: The outbound-full flag is set by a slave write with `slv_sel`=2, which also loads `slv_wdata` into the outbound byte. It is cleared by a hitting host read with `host_addr[2]`=0. When both happen in the same cycle, the flag stays set.
- R9: After reset, the inbound byte, the outbound byte, the command marker and both flags are 0, and `host_rvalid` and `host_rdata` are 0.
- R10: `slv_rdata` shows the inbound byte for `slv_sel`=0, the status byte for 1 and the outbound byte for 2, and reads 0x00 for 3. A slave write with any `slv_sel` other than 2 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base | input | 16 | Channel base address (bit 2 unused) |
| host_addr | input | 16 | Host I/O address |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid with host_rvalid |
| host_rvalid | output | 1 | High the cycle after a hitting host read |
| slv_sel | input | 2 | Slave register select: 0 inbound, 1 status, 2 outbound |
| slv_rd | input | 1 | Slave read strobe |
| slv_wr | input | 1 | Slave write strobe |
| slv_wdata | input | 8 | Slave write data |
| slv_rdata | output | 8 | Slave read data, combinational |

## Verification
Two pairs of events can land on the same edge. A host write can coincide with the slave reading the inbound byte, and a slave write of the outbound byte can coincide with a host read of it. The bench drives these pairs both as directed cycles and through random stimulus in which host and slave operations are drawn independently each cycle. For each cycle, a bench model decides that the set wins over the clear. It also expects both readers to see the pre-edge contents. The status byte is then read back from both sides to confirm the flag values.

// File: rtl/hmbox_pkg.sv
// Package: shared widths, status bit positions and slave select codes
// for the host/slave mailbox channel.
package hmbox_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    // Status byte bit positions
    localparam int ST_OBF = 0;
    localparam int ST_IBF = 1;
    localparam int ST_CMD = 3;

    // Slave register select codes
    typedef enum logic [1:0] {
        SLV_INBOUND  = 2'd0,
        SLV_STATUS   = 2'd1,
        SLV_OUTBOUND = 2'd2,
        SLV_NONE     = 2'd3
    } slv_sel_e;

    // Assemble the status byte; undefined bits are zero.
    function automatic logic [DATA_W-1:0] make_status(input logic obf,
                                                      input logic ibf,
                                                      input logic cmd);
        logic [DATA_W-1:0] s;
        s         = '0;
        s[ST_OBF] = obf;
        s[ST_IBF] = ibf;
        s[ST_CMD] = cmd;
        return s;
    endfunction

endpackage

// File: rtl/hmbox_decode.sv
// Module: hmbox_decode
// Purpose: compares the host address with the configured base address and
// outputs the hit and the register-select bit.
// Assumes: the select bit lies inside the address word and is left out of
// the match. Overlap with other channels is resolved by the integrator.
module hmbox_decode #(
    parameter int AW      = 16,
    parameter int SEL_BIT = 2
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    output logic          hit,
    output logic          sel
);
    localparam logic [AW-1:0] MATCH_MASK = ~(AW'(1) << SEL_BIT);

    // Match every address bit except the select bit.
    always_comb begin
        hit = ((addr ^ base) & MATCH_MASK) == '0;
        sel = addr[SEL_BIT];
    end
endmodule

// File: rtl/hmbox_inbox.sv
// Module: hmbox_inbox
// Purpose: the inbound byte from host to slave, its command marker and its
// full flag.
// Assumes: wr_en is already qualified by the address hit. rd_clr is a slave
// read of the inbound byte. When both arrive together, the set wins.
module hmbox_inbox #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_cmd,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_clr,
    output logic [DW-1:0] data,
    output logic          cmd,
    output logic          full
);
    // Capture the host byte and its command marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
            cmd  <= 1'b0;
        end else if (wr_en) begin
            data <= wr_data;
            cmd  <= wr_cmd;
        end
    end

    // Full flag: set by a host write, cleared by a slave read; the set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)      full <= 1'b0;
        else if (wr_en)  full <= 1'b1;
        else if (rd_clr) full <= 1'b0;
    end

    AST_IBF_SET:   assert property (@(posedge clk) disable iff (!rst_n)
                       wr_en |=> full);                          // R7
    AST_IBF_CLR:   assert property (@(posedge clk) disable iff (!rst_n)
                       (rd_clr && !wr_en) |=> !full);            // R7
    AST_CMD_MARK:  assert property (@(posedge clk) disable iff (!rst_n)
                       wr_en |=> (cmd == $past(wr_cmd)));         // R3
    AST_IN_HOLD:   assert property (@(posedge clk) disable iff (!rst_n)
                       !wr_en |=> ($stable(data) && $stable(cmd))); // R6
endmodule

// File: rtl/hmbox_outbox.sv
// Module: hmbox_outbox
// Purpose: the outbound byte from slave to host and its full flag.
// Assumes: host_take is already qualified by the hit and the data-port
// select. When a slave write and a host read arrive together, the set wins.
module hmbox_outbox #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          host_take,
    output logic [DW-1:0] data,
    output logic          full
);
    // Load the outbound byte from the slave.
    always_ff @(posedge clk) begin
        if (!rst_n)     data <= '0;
        else if (wr_en) data <= wr_data;
    end

    // Full flag: set by a slave write, cleared by a host read; the set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)         full <= 1'b0;
        else if (wr_en)     full <= 1'b1;
        else if (host_take) full <= 1'b0;
    end

    AST_OBF_SET:  assert property (@(posedge clk) disable iff (!rst_n)
                      wr_en |=> full);                           // R8
    AST_OBF_CLR:  assert property (@(posedge clk) disable iff (!rst_n)
                      (host_take && !wr_en) |=> !full);          // R8
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                      !wr_en |=> $stable(data));                 // R10
endmodule

// File: rtl/hmbox_channel.sv
// Module: hmbox_channel
// Purpose: top of the host/slave byte mailbox. It decodes host accesses,
// steers host writes to the inbox, and returns the outbound byte or the
// status byte to the host one cycle after a hitting read. It also serves
// combinational slave reads.
// Assumes: each strobe lasts one cycle per transfer. cfg_base is static
// while accesses are in flight.
module hmbox_channel
    import hmbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    input  logic [1:0]        slv_sel,
    input  logic              slv_rd,
    input  logic              slv_wr,
    input  logic [DATA_W-1:0] slv_wdata,
    output logic [DATA_W-1:0] slv_rdata
);
    logic              hit, sel_ctl;
    logic              hwr_hit, hrd_hit, host_take;
    logic              slv_in_rd, slv_out_wr;
    logic [DATA_W-1:0] in_data, out_data, status;
    logic              in_cmd, in_full, out_full;

    hmbox_decode #(.AW(ADDR_W), .SEL_BIT(2)) u_decode (
        .addr (host_addr),
        .base (cfg_base),
        .hit  (hit),
        .sel  (sel_ctl)
    );

    // Qualify the strobes of both sides.
    always_comb begin
        hwr_hit    = host_wr && hit;
        hrd_hit    = host_rd && hit;
        host_take  = hrd_hit && !sel_ctl;
        slv_in_rd  = slv_rd && (slv_sel == SLV_INBOUND);
        slv_out_wr = slv_wr && (slv_sel == SLV_OUTBOUND);
    end

    hmbox_inbox #(.DW(DATA_W)) u_inbox (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (hwr_hit),
        .wr_cmd  (sel_ctl),
        .wr_data (host_wdata),
        .rd_clr  (slv_in_rd),
        .data    (in_data),
        .cmd     (in_cmd),
        .full    (in_full)
    );

    hmbox_outbox #(.DW(DATA_W)) u_outbox (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (slv_out_wr),
        .wr_data   (slv_wdata),
        .host_take (host_take),
        .data      (out_data),
        .full      (out_full)
    );

    // Build the status byte from the current flags.
    always_comb status = make_status(out_full, in_full, in_cmd);

    // Register the host read response: pre-edge content, zero on miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rvalid <= 1'b0;
            host_rdata  <= '0;
        end else begin
            host_rvalid <= hrd_hit;
            host_rdata  <= !hrd_hit ? '0 : (sel_ctl ? status : out_data);
        end
    end

    // Combinational slave read mux.
    always_comb begin
        unique case (slv_sel)
            SLV_INBOUND:  slv_rdata = in_data;
            SLV_STATUS:   slv_rdata = status;
            SLV_OUTBOUND: slv_rdata = out_data;
            default:      slv_rdata = '0;
        endcase
    end

    AST_MISS_NOVALID: assert property (@(posedge clk) disable iff (!rst_n)
                          (host_rd && !hit) |=> !host_rvalid);   // R6
    AST_RD_VALID:     assert property (@(posedge clk) disable iff (!rst_n)
                          hrd_hit |=> host_rvalid);              // R4
    AST_STATUS_RSVD:  assert property (@(posedge clk) disable iff (!rst_n)
                          (host_rvalid && $past(sel_ctl)) |->
                          ((host_rdata & 8'hF4) == 8'h00));      // R5
    AST_RDATA_IDLE:   assert property (@(posedge clk) disable iff (!rst_n)
                          !host_rvalid |-> (host_rdata == 8'h00)); // R6
endmodule

// File: tb/hmbox_channel_bench.sv
// Bench for hmbox_channel. It mixes directed corner cases with seeded
// random traffic and checks the outputs against a reference model kept
// in the bench.
module hmbox_channel_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cfg_base, host_addr;
    logic        host_wr, host_rd, slv_rd, slv_wr;
    logic [7:0]  host_wdata, host_rdata, slv_wdata, slv_rdata;
    logic        host_rvalid;
    logic [1:0]  slv_sel;

    int total = 0;
    int bad   = 0;

    // Reference model
    logic [7:0] m_in, m_out;
    logic       m_cmd, m_ibf, m_obf;

    always #2 clk = ~clk;  // 250 MHz

    hmbox_channel u_hmbox_channel (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base),
        .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .slv_sel(slv_sel), .slv_rd(slv_rd),
        .slv_wr(slv_wr), .slv_wdata(slv_wdata), .slv_rdata(slv_rdata)
    );

    function automatic logic [7:0] exp_status();
        logic [7:0] s = 8'h00;
        s[0] = m_obf; s[1] = m_ibf; s[3] = m_cmd;
        return s;
    endfunction

    function automatic logic exp_hit(input logic [15:0] a);
        return (a[15:3] == cfg_base[15:3]) && (a[1:0] == cfg_base[1:0]);
    endfunction

    function automatic logic [7:0] exp_slave(input logic [1:0] s);
        case (s)
            2'd0:    return m_in;
            2'd1:    return exp_status();
            2'd2:    return m_out;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act,
                         input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, check slave read, model the edge,
    // then check the registered host response.
    task automatic cyc(input logic hw, input logic hr, input logic [15:0] a,
                       input logic [7:0] wd, input logic sr, input logic sw,
                       input logic [1:0] sel, input logic [7:0] swd);
        logic       h, ev;
        logic [7:0] ed;
        string      tag;
        @(negedge clk);
        host_wr = hw; host_rd = hr; host_addr = a; host_wdata = wd;
        slv_rd = sr; slv_wr = sw; slv_sel = sel; slv_wdata = swd;
        #1;
        check(sel == 2'd3 ? "R10 unused select" : "R10 slave read",
              slv_rdata, exp_slave(sel));
        h  = exp_hit(a);
        ev = hr && h;
        ed = !ev ? 8'h00 : (a[2] ? exp_status() : m_out);
        tag = !hr ? "R6 idle" : (!h ? "R6 miss read" :
              (a[2] ? "R5 status read" : "R4 data read"));
        // Model update, set wins over clear
        if (hw && h) begin
            m_in = wd; m_cmd = a[2]; m_ibf = 1'b1;
        end else if (sr && sel == 2'd0) m_ibf = 1'b0;
        if (sw && sel == 2'd2) begin
            m_out = swd; m_obf = 1'b1;
        end else if (ev && !a[2]) m_obf = 1'b0;
        @(posedge clk); #1;
        check(tag, {7'd0, host_rvalid}, {7'd0, ev});
        check(tag, host_rdata, ed);
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, 16'h0, 8'h0, 1'b0, 1'b0, 2'd3, 8'h0);
    endtask

    function automatic logic [15:0] hit_addr(input logic b2);
        return {cfg_base[15:3], b2, cfg_base[1:0]};
    endfunction

    initial begin : watchdog
        #400000;
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [15:0] a;
        logic [31:0] r;
        void'($urandom(32'd1234));
        cfg_base = 16'h0CA6;  // bit 2 set in the base: must not matter (R1)
        rst_n = 1'b0;
        host_wr = 0; host_rd = 0; host_addr = 0; host_wdata = 0;
        slv_rd = 0; slv_wr = 0; slv_sel = 0; slv_wdata = 0;
        m_in = 0; m_out = 0; m_cmd = 0; m_ibf = 0; m_obf = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R9: reset state seen from both sides
        check("R9 rvalid", {7'd0, host_rvalid}, 8'h00);
        check("R9 rdata", host_rdata, 8'h00);
        for (int s = 0; s < 4; s++) begin
            slv_sel = 2'(s); #1;
            check("R9 slave reg", slv_rdata, 8'h00);
        end

        // R2 / R3: data then command writes, status via host and slave
        cyc(1, 0, hit_addr(1'b0), 8'h5A, 0, 0, 2'd0, 8'h0);      // R2
        cyc(0, 1, hit_addr(1'b1), 8'h0, 0, 0, 2'd1, 8'h0);       // R5
        cyc(1, 0, hit_addr(1'b1), 8'hC3, 0, 0, 2'd1, 8'h0);      // R3
        cyc(0, 1, hit_addr(1'b1), 8'h0, 1, 0, 2'd0, 8'h0);       // R7 clear
        cyc(0, 0, 16'h0, 8'h0, 0, 0, 2'd1, 8'h0);
        // R6: misses differing in bit 3 and in bit 0 change nothing
        cyc(1, 0, hit_addr(1'b0) ^ 16'h0008, 8'hEE, 0, 0, 2'd0, 8'h0);
        cyc(0, 1, hit_addr(1'b0) ^ 16'h0001, 8'h0, 0, 0, 2'd1, 8'h0);
        // R7: host write and slave inbound read together keep IBF set
        cyc(1, 0, hit_addr(1'b0), 8'h77, 1, 0, 2'd0, 8'h0);
        cyc(0, 0, 16'h0, 8'h0, 0, 0, 2'd1, 8'h0);
        // R8: slave write, then host read clears, then overlap keeps set
        cyc(0, 0, 16'h0, 8'h0, 0, 1, 2'd2, 8'hA5);
        cyc(0, 1, hit_addr(1'b0), 8'h0, 0, 0, 2'd1, 8'h0);
        cyc(0, 1, hit_addr(1'b0), 8'h0, 0, 1, 2'd2, 8'h3C);
        cyc(0, 1, hit_addr(1'b1), 8'h0, 0, 0, 2'd1, 8'h0);
        // R10: slave writes on other selects are ignored
        cyc(0, 0, 16'h0, 8'h0, 0, 1, 2'd0, 8'hFF);
        cyc(0, 0, 16'h0, 8'h0, 0, 1, 2'd1, 8'hFF);
        cyc(0, 0, 16'h0, 8'h0, 0, 1, 2'd3, 8'hFF);
        idle();
        for (int s = 0; s < 4; s++)
            cyc(0, 0, 16'h0, 8'h0, 0, 0, 2'(s), 8'h0);

        // Seeded random traffic with near-miss addresses (R1)
        for (int i = 0; i < 3000; i++) begin
            r = $urandom();
            a = hit_addr(r[0]);
            if (r[3:1] == 3'd0) a = a ^ (16'h0008 << r[7:4]);
            else if (r[3:1] == 3'd1) a = a ^ {14'd0, r[9:8] | 2'b01};
            cyc(r[10] & ~r[11], r[11], a, r[19:12], r[20], r[21],
                r[23:22], r[31:24]);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule